// File: doc/BRIEF.md
# 8-bit ALU with flag generation

A purely combinational arithmetic and logic unit for an 8-bit accumulator datapath. Each cycle it receives the accumulator value, a second 8-bit operand, a 4-bit operation code and the current flag byte. It returns the 8-bit result and the next flag byte. Every operation has its own rule for which flags it computes, which it forces and which it leaves as they came in. The P/V flag carries signed overflow for arithmetic and even parity for logic and decimal adjust.

The surrounding core decodes instructions and picks operands. It writes `result_o` back to the destination register, except for compare, carry-flag and pass operations, where the result simply mirrors the accumulator. It always writes `flags_o` back to the flag register. Increment and decrement act on the second operand, so any 8-bit register can be routed through them. Negate, complement and decimal adjust act on the accumulator.

Top module: `alu8_core`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, INC=5, DEC=6, NEG=7, AND=8, OR=9, XOR=10, CPL=11, SCF=12, CCF=13, DAA=14, PASS=15. The flag byte places S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0. Bits 5 and 3 are copied from `flags_i` for every operation.
- R2: ADD gives acc+opnd and ADC gives acc+opnd+C. C is the carry out of bit 7, H is the carry out of bit 3, P/V is signed overflow, N is 0, S is result bit 7 and Z marks a zero result.
- R3: SUB gives acc-opnd and SBC gives acc-opnd-C. C is the borrow out of bit 7, H is the borrow out of bit 3, P/V is signed overflow, N is 1, and S and Z follow the result.
- R4: CMP sets the flags exactly as SUB would, and `result_o` equals `acc_i`. Equal inputs give Z=1 and C=0. An unsigned smaller accumulator gives C=1 and Z=0. A larger one clears both.
- R5: INC gives opnd+1 with N=0, and DEC gives opnd-1 with N=1. C is kept. P/V is set for 0x7F→0x80 (INC) and 0x80→0x7F (DEC). H is the carry or borrow across bit 3. S and Z follow the result.
- R6: NEG gives 0-acc with N=1. P/V is set only for 0x80. C is set when acc is nonzero. H is the borrow out of bit 3.
- R7: AND, OR and XOR clear C and N. P/V is 1 when the result has an even number of ones. H is 1 for AND and 0 for OR and XOR. S and Z follow the result.
- R8: CPL returns the bitwise inverse of acc and sets H and N. S, Z, P/V and C are kept.
- R9: SCF sets C and clears H and N. CCF inverts C, loads H with the old C and clears N. Both keep S, Z and P/V, and their result equals acc.
- R10: DAA adds 0x06 when acc[3:0]>9 or H=1. It then adds 0x60 when the upper nibble of that intermediate value is >9 or C=1. C ends as 1 only if the second correction was made. H is the carry out of bit 3 from the first correction. N is kept, P/V is even parity, and S and Z follow the result.
- R11: PASS returns acc and leaves the flag byte exactly as it came in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand; INC and DEC act on it |
| op_i | input | 4 | Operation code (R1) |
| flags_i | input | 8 | Incoming flag byte |
| result_o | output | 8 | Operation result |
| flags_o | output | 8 | Updated flag byte |

## Verification
No register lies between any input and either output, so both the result and every flag are due in the same cycle the inputs are applied. There is no cycle of latency. The bench drives a new vector just after each rising edge and compares both outputs at the following falling edge, half a period later, once the logic has settled. A behavioural integer model in the bench, evaluated on the same vector, supplies the expected values. These include the DAA intermediate nibble and the borrow sign of subtraction.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBC  = 4'd3,
      OP_CMP  = 4'd4,
      OP_INC  = 4'd5,
      OP_DEC  = 4'd6,
      OP_NEG  = 4'd7,
      OP_AND  = 4'd8,
      OP_OR   = 4'd9,
      OP_XOR  = 4'd10,
      OP_CPL  = 4'd11,
      OP_SCF  = 4'd12,
      OP_CCF  = 4'd13,
      OP_DAA  = 4'd14,
      OP_PASS = 4'd15
   } alu_op_e;

   localparam int FLAG_W = 8;
   localparam int FB_C   = 0;
   localparam int FB_N   = 1;
   localparam int FB_PV  = 2;
   localparam int FB_H   = 4;
   localparam int FB_Z   = 6;
   localparam int FB_S   = 7;

   typedef enum logic [1:0] {
      BW_AND = 2'd0,
      BW_OR  = 2'd1,
      BW_XOR = 2'd2,
      BW_INV = 2'd3
   } bw_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int DATA_W     = 8,
   parameter int ADDER_ARCH = 0
) (
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              half_carry_o,
   output logic              carry_o,
   output logic              ovf_o
);
   localparam int NIB_W = DATA_W / 2;
   localparam int HI_W  = DATA_W - NIB_W;

   generate
      if (ADDER_ARCH == 0) begin : g_split
         logic [NIB_W:0] lo_sum;
         logic [HI_W:0]  hi_sum;
         assign lo_sum = {1'b0, x_i[NIB_W-1:0]} + {1'b0, y_i[NIB_W-1:0]}
                       + {{NIB_W{1'b0}}, cin_i};
         assign hi_sum = {1'b0, x_i[DATA_W-1:NIB_W]} + {1'b0, y_i[DATA_W-1:NIB_W]}
                       + {{HI_W{1'b0}}, lo_sum[NIB_W]};
         assign sum_o        = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
         assign half_carry_o = lo_sum[NIB_W];
         assign carry_o      = hi_sum[HI_W];
         assign ovf_o        = (x_i[DATA_W-1] == y_i[DATA_W-1]) &&
                               (sum_o[DATA_W-1] != x_i[DATA_W-1]);
      end else begin : g_ripple
         logic [DATA_W:0] cy;
         assign cy[0] = cin_i;
         for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
            assign sum_o[gi]  = x_i[gi] ^ y_i[gi] ^ cy[gi];
            assign cy[gi+1]   = (x_i[gi] & y_i[gi]) | (cy[gi] & (x_i[gi] ^ y_i[gi]));
         end
         assign half_carry_o = cy[NIB_W];
         assign carry_o      = cy[DATA_W];
         assign ovf_o        = cy[DATA_W] ^ cy[DATA_W-1];
      end
   endgenerate
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  bw_sel_e           sel_i,
   output logic [DATA_W-1:0] out_o,
   output logic              even_par_o
);
   always_comb begin
      unique case (sel_i)
         BW_AND:  out_o = a_i & b_i;
         BW_OR:   out_o = a_i | b_i;
         BW_XOR:  out_o = a_i ^ b_i;
         default: out_o = ~a_i;
      endcase
   end

   assign even_par_o = ~(^out_o);
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] acc_i,
   input  logic              h_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] res_o,
   output logic              h_o,
   output logic              c_o,
   output logic              even_par_o
);
   localparam int NIB_W = DATA_W / 2;
   localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
   localparam logic [DATA_W-1:0] LO_CORR   = DATA_W'(6);
   localparam logic [DATA_W-1:0] HI_CORR   = LO_CORR << NIB_W;

   logic              lo_fix;
   logic              hi_fix;
   logic [NIB_W:0]    lo_nib_sum;
   logic [DATA_W-1:0] step1;

   assign lo_fix     = (acc_i[NIB_W-1:0] > DIGIT_MAX) | h_i;
   assign lo_nib_sum = {1'b0, acc_i[NIB_W-1:0]} +
                       (lo_fix ? {1'b0, LO_CORR[NIB_W-1:0]} : '0);
   assign step1      = acc_i + (lo_fix ? LO_CORR : '0);
   assign hi_fix     = (step1[DATA_W-1:NIB_W] > DIGIT_MAX) | c_i;
   assign res_o      = step1 + (hi_fix ? HI_CORR : '0);
   assign h_o        = lo_nib_sum[NIB_W];
   assign c_o        = hi_fix;
   assign even_par_o = ~(^res_o);
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int ADDER_ARCH      = 0,
   parameter bit CCF_H_OLD_CARRY = 1'b1
) (
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [3:0]        op_i,
   input  logic [7:0]        flags_i,
   output logic [DATA_W-1:0] result_o,
   output logic [7:0]        flags_o
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("alu8_core: DATA_W must be 8 to match the flag byte and decimal adjust");
      end
      if (ADDER_ARCH < 0 || ADDER_ARCH > 1) begin : g_bad_arch
         $error("alu8_core: ADDER_ARCH must be 0 (split) or 1 (ripple)");
      end
   endgenerate

   localparam logic [DATA_W-1:0] MINUS_ONE_INV = {{(DATA_W-1){1'b1}}, 1'b0};

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   logic c_in;
   assign c_in = flags_i[FB_C];

   // operand steering for the shared adder
   logic [DATA_W-1:0] add_x, add_y;
   logic              add_ci, subtract;

   always_comb begin
      add_x    = acc_i;
      add_y    = opnd_i;
      add_ci   = 1'b0;
      subtract = 1'b0;
      unique case (op)
         OP_ADC: add_ci = c_in;
         OP_SUB, OP_CMP: begin
            add_y    = ~opnd_i;
            add_ci   = 1'b1;
            subtract = 1'b1;
         end
         OP_SBC: begin
            add_y    = ~opnd_i;
            add_ci   = ~c_in;
            subtract = 1'b1;
         end
         OP_INC: begin
            add_x  = opnd_i;
            add_y  = '0;
            add_ci = 1'b1;
         end
         OP_DEC: begin
            add_x    = opnd_i;
            add_y    = MINUS_ONE_INV;
            add_ci   = 1'b1;
            subtract = 1'b1;
         end
         OP_NEG: begin
            add_x    = '0;
            add_y    = ~acc_i;
            add_ci   = 1'b1;
            subtract = 1'b1;
         end
         default: ;
      endcase
   end

   logic [DATA_W-1:0] sum;
   logic              sum_hc, sum_co, sum_ov;

   alu8_addsub #(
      .DATA_W     (DATA_W),
      .ADDER_ARCH (ADDER_ARCH)
   ) u_addsub (
      .x_i          (add_x),
      .y_i          (add_y),
      .cin_i        (add_ci),
      .sum_o        (sum),
      .half_carry_o (sum_hc),
      .carry_o      (sum_co),
      .ovf_o        (sum_ov)
   );

   logic arith_h, arith_c;
   assign arith_h = sum_hc ^ subtract;
   assign arith_c = sum_co ^ subtract;

   // bitwise unit
   bw_sel_e           bw_sel;
   logic [DATA_W-1:0] bw_out;
   logic              bw_par;

   always_comb begin
      unique case (op)
         OP_AND:  bw_sel = BW_AND;
         OP_OR:   bw_sel = BW_OR;
         OP_XOR:  bw_sel = BW_XOR;
         default: bw_sel = BW_INV;
      endcase
   end

   alu8_bitwise #(
      .DATA_W (DATA_W)
   ) u_bitwise (
      .a_i        (acc_i),
      .b_i        (opnd_i),
      .sel_i      (bw_sel),
      .out_o      (bw_out),
      .even_par_o (bw_par)
   );

   // decimal adjust
   logic [DATA_W-1:0] daa_res;
   logic              daa_h, daa_c, daa_par;

   alu8_decadj #(
      .DATA_W (DATA_W)
   ) u_decadj (
      .acc_i      (acc_i),
      .h_i        (flags_i[FB_H]),
      .c_i        (c_in),
      .res_o      (daa_res),
      .h_o        (daa_h),
      .c_o        (daa_c),
      .even_par_o (daa_par)
   );

   // half-carry choice for the carry-complement operation
   logic ccf_h;
   generate
      if (CCF_H_OLD_CARRY) begin : g_ccf_h_carry
         assign ccf_h = c_in;
      end else begin : g_ccf_h_zero
         assign ccf_h = 1'b0;
      end
   endgenerate

   // result and flag assembly
   always_comb begin
      result_o = acc_i;
      flags_o  = flags_i;
      unique case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
            result_o       = (op == OP_CMP) ? acc_i : sum;
            flags_o[FB_S]  = sum[DATA_W-1];
            flags_o[FB_Z]  = (sum == '0);
            flags_o[FB_H]  = arith_h;
            flags_o[FB_PV] = sum_ov;
            flags_o[FB_N]  = subtract;
            flags_o[FB_C]  = arith_c;
         end
         OP_INC, OP_DEC: begin
            result_o       = sum;
            flags_o[FB_S]  = sum[DATA_W-1];
            flags_o[FB_Z]  = (sum == '0);
            flags_o[FB_H]  = arith_h;
            flags_o[FB_PV] = sum_ov;
            flags_o[FB_N]  = subtract;
         end
         OP_AND, OP_OR, OP_XOR: begin
            result_o       = bw_out;
            flags_o[FB_S]  = bw_out[DATA_W-1];
            flags_o[FB_Z]  = (bw_out == '0);
            flags_o[FB_H]  = (op == OP_AND);
            flags_o[FB_PV] = bw_par;
            flags_o[FB_N]  = 1'b0;
            flags_o[FB_C]  = 1'b0;
         end
         OP_CPL: begin
            result_o      = bw_out;
            flags_o[FB_H] = 1'b1;
            flags_o[FB_N] = 1'b1;
         end
         OP_SCF: begin
            flags_o[FB_C] = 1'b1;
            flags_o[FB_H] = 1'b0;
            flags_o[FB_N] = 1'b0;
         end
         OP_CCF: begin
            flags_o[FB_C] = ~c_in;
            flags_o[FB_H] = ccf_h;
            flags_o[FB_N] = 1'b0;
         end
         OP_DAA: begin
            result_o       = daa_res;
            flags_o[FB_S]  = daa_res[DATA_W-1];
            flags_o[FB_Z]  = (daa_res == '0);
            flags_o[FB_H]  = daa_h;
            flags_o[FB_PV] = daa_par;
            flags_o[FB_C]  = daa_c;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic [DATA_W-1:0] acc_i,
   input logic [DATA_W-1:0] opnd_i,
   input logic [3:0]        op_i,
   input logic [7:0]        flags_i,
   input logic [DATA_W-1:0] result_o,
   input logic [7:0]        flags_o
);
   always_comb begin
      assert_spare_bits_R1: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3])
         else $error("spare flag bits altered");

      if (op_i == OP_CMP) begin
         assert_cmp_order_R4: assert (result_o == acc_i && flags_o[FB_N] &&
                                      flags_o[FB_Z] == (acc_i == opnd_i) &&
                                      flags_o[FB_C] == (acc_i < opnd_i))
            else $error("compare outcome wrong");
      end

      if (op_i == OP_INC || op_i == OP_DEC) begin
         assert_incdec_keep_carry_R5: assert (flags_o[FB_C] == flags_i[FB_C])
            else $error("inc/dec changed carry");
      end

      if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) begin
         assert_logic_clear_cn_R7: assert (!flags_o[FB_C] && !flags_o[FB_N])
            else $error("logic op left C or N set");
      end

      if (op_i == OP_CPL) begin
         assert_cpl_flags_R8: assert (flags_o[FB_H] && flags_o[FB_N] &&
                                      flags_o[FB_S] == flags_i[FB_S] &&
                                      flags_o[FB_Z] == flags_i[FB_Z] &&
                                      flags_o[FB_PV] == flags_i[FB_PV] &&
                                      flags_o[FB_C] == flags_i[FB_C])
            else $error("complement flags wrong");
      end

      if (op_i == OP_SCF || op_i == OP_CCF) begin
         assert_carry_ops_R9: assert (result_o == acc_i && !flags_o[FB_N] &&
                                      flags_o[FB_Z] == flags_i[FB_Z])
            else $error("carry op disturbed result or flags");
      end

      if (op_i == OP_PASS) begin
         assert_pass_R11: assert (result_o == acc_i && flags_o == flags_i)
            else $error("pass op changed state");
      end
   end
endmodule

bind alu8_core alu8_core_chk #(
   .DATA_W (DATA_W)
) u_alu8_core_chk (
   .acc_i    (acc_i),
   .opnd_i   (opnd_i),
   .op_i     (op_i),
   .flags_i  (flags_i),
   .result_o (result_o),
   .flags_o  (flags_o)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 3000;

   logic       clk = 1'b0;
   logic [7:0] acc, opnd, flags_in;
   logic [3:0] op;
   logic [7:0] result, flags_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu8_core i_alu8_core (
      .acc_i    (acc),
      .opnd_i   (opnd),
      .op_i     (op),
      .flags_i  (flags_in),
      .result_o (result),
      .flags_o  (flags_out)
   );

   function automatic bit even_ones(input int v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += (v >> i) & 1;
      return (n % 2) == 0;
   endfunction

   function automatic int signed8(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   // behavioural reference: {result, flags}
   function automatic logic [15:0] ref_alu(input int o, input int a, input int b,
                                           input logic [7:0] f);
      logic [7:0] fo = f;
      int res = a;
      int c   = f[0];
      int r, ci, sr, t;
      bit sz  = 1'b0;
      case (o)
         0, 1: begin
            ci = (o == 1) ? c : 0;
            r = a + b + ci; res = r & 255;
            fo[0] = r > 255;
            fo[4] = ((a & 15) + (b & 15) + ci) > 15;
            sr = signed8(a) + signed8(b) + ci;
            fo[2] = (sr > 127) || (sr < -128);
            fo[1] = 0; sz = 1;
         end
         2, 3, 4: begin
            ci = (o == 3) ? c : 0;
            r = a - b - ci; res = r & 255;
            fo[0] = r < 0;
            fo[4] = ((a & 15) - (b & 15) - ci) < 0;
            sr = signed8(a) - signed8(b) - ci;
            fo[2] = (sr > 127) || (sr < -128);
            fo[1] = 1; sz = 1;
         end
         5: begin
            res = (b + 1) & 255;
            fo[4] = (b & 15) == 15; fo[2] = (b == 127); fo[1] = 0; sz = 1;
         end
         6: begin
            res = (b - 1) & 255;
            fo[4] = (b & 15) == 0; fo[2] = (b == 128); fo[1] = 1; sz = 1;
         end
         7: begin
            res = (0 - a) & 255;
            fo[0] = a != 0; fo[4] = (a & 15) != 0; fo[2] = (a == 128);
            fo[1] = 1; sz = 1;
         end
         8, 9, 10: begin
            res = (o == 8) ? (a & b) : (o == 9) ? (a | b) : (a ^ b);
            fo[4] = (o == 8); fo[2] = even_ones(res);
            fo[1] = 0; fo[0] = 0; sz = 1;
         end
         11: begin
            res = (~a) & 255; fo[4] = 1; fo[1] = 1;
         end
         12: begin
            fo[0] = 1; fo[4] = 0; fo[1] = 0;
         end
         13: begin
            fo[4] = f[0]; fo[0] = !f[0]; fo[1] = 0;
         end
         14: begin
            t = a;
            if ((t & 15) > 9 || f[4]) begin
               fo[4] = ((t & 15) + 6) > 15;
               t = (t + 6) & 255;
            end else fo[4] = 0;
            if ((t >> 4) > 9 || f[0]) begin
               t = (t + 96) & 255; fo[0] = 1;
            end else fo[0] = 0;
            res = t; fo[2] = even_ones(res); sz = 1;
         end
         default: ;
      endcase
      if (sz) begin
         fo[7] = (res >> 7) & 1;
         fo[6] = (res == 0);
      end
      if (o == 4) begin
         fo[7] = (((a - b) & 255) >> 7) & 1;
         fo[6] = (a == b);
         res   = a;
      end
      return {res[7:0], fo};
   endfunction

   function automatic string req_of(input int o);
      case (o)
         0, 1:     return "R2";
         2, 3:     return "R3";
         4:        return "R4";
         5, 6:     return "R5";
         7:        return "R6";
         8, 9, 10: return "R7";
         11:       return "R8";
         12, 13:   return "R9";
         14:       return "R10";
         default:  return "R11";
      endcase
   endfunction

   task automatic run_vec(input int o, input int a, input int b,
                          input logic [7:0] f, input string req);
      logic [15:0] expv;
      @(posedge clk);
      #1;
      op = 4'(o); acc = 8'(a); opnd = 8'(b); flags_in = f;
      @(negedge clk);
      expv = ref_alu(o, a, b, f);
      checks++;
      if (result !== expv[15:8] || flags_out !== expv[7:0]) begin
         fails++;
         $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: got res=%02h flags=%02h, expected res=%02h flags=%02h",
                  req, o, a, b, f, result, flags_out, expv[15:8], expv[7:0]);
      end
   endtask

   task automatic check_val(input string req, input logic [7:0] got, input logic [7:0] exp_v);
      checks++;
      if (got !== exp_v) begin
         fails++;
         $display("FAIL %s: got %02h, expected %02h", req, got, exp_v);
      end
   endtask

   initial begin
      op = 4'd15; acc = 8'h00; opnd = 8'h00; flags_in = 8'h00;
      // initial state under PASS: outputs mirror inputs (R11)
      @(negedge clk);
      check_val("R11", result, 8'h00);
      check_val("R11", flags_out, 8'h00);

      run_vec(15, 8'h3C, 8'hA5, 8'hD7, "R11");
      // spare bits 5 and 3 travel through (R1)
      run_vec(0, 8'h01, 8'h02, 8'h28, "R1");
      check_val("R1", flags_out & 8'h28, 8'h28);
      run_vec(8, 8'h00, 8'h00, 8'h28, "R1");

      // R2
      run_vec(0, 8'h7F, 8'h01, 8'h00, "R2");
      check_val("R2", flags_out, 8'h94);
      run_vec(0, 8'hFF, 8'h01, 8'h00, "R2");
      check_val("R2", flags_out, 8'h51);
      run_vec(1, 8'h10, 8'h20, 8'h01, "R2");
      check_val("R2", result, 8'h31);

      // R3
      run_vec(2, 8'h80, 8'h01, 8'h00, "R3");
      check_val("R3", flags_out, 8'h16);
      run_vec(3, 8'h00, 8'h00, 8'h01, "R3");
      check_val("R3", result, 8'hFF);

      // R4
      run_vec(4, 8'h42, 8'h42, 8'h00, "R4");
      check_val("R4", flags_out & 8'h41, 8'h40);
      run_vec(4, 8'h10, 8'h20, 8'h00, "R4");
      check_val("R4", flags_out & 8'h41, 8'h01);
      run_vec(4, 8'h90, 8'h20, 8'h41, "R4");
      check_val("R4", flags_out & 8'h41, 8'h00);

      // R5
      run_vec(5, 8'h00, 8'h7F, 8'h00, "R5");
      check_val("R5", result, 8'h80);
      run_vec(5, 8'h00, 8'hFF, 8'h01, "R5");
      check_val("R5", flags_out & 8'h41, 8'h41);
      run_vec(6, 8'h00, 8'h80, 8'h00, "R5");
      run_vec(6, 8'h00, 8'h00, 8'h00, "R5");

      // R6
      run_vec(7, 8'h00, 8'h00, 8'h00, "R6");
      run_vec(7, 8'h80, 8'h00, 8'h00, "R6");
      check_val("R6", flags_out & 8'h07, 8'h07);
      run_vec(7, 8'h01, 8'h00, 8'h00, "R6");
      check_val("R6", result, 8'hFF);

      // R7
      run_vec(8, 8'h2E, 8'h9D, 8'h03, "R7");
      check_val("R7", result, 8'h0C);
      run_vec(9, 8'h2E, 8'h9D, 8'h13, "R7");
      check_val("R7", result, 8'hBF);
      run_vec(10, 8'h2E, 8'h9D, 8'h03, "R7");
      check_val("R7", result, 8'hB3);

      // R8
      run_vec(11, 8'h5A, 8'h00, 8'hC5, "R8");
      check_val("R8", flags_out, 8'hD7);

      // R9
      run_vec(12, 8'h11, 8'h00, 8'hD6, "R9");
      check_val("R9", flags_out, 8'hC5);
      run_vec(13, 8'h11, 8'h00, 8'h01, "R9");
      check_val("R9", flags_out, 8'h10);
      run_vec(13, 8'h11, 8'h00, 8'h02, "R9");

      // R10
      run_vec(14, 8'h9A, 8'h00, 8'h00, "R10");
      check_val("R10", flags_out, 8'h55);
      run_vec(14, 8'h15, 8'h00, 8'h00, "R10");
      run_vec(14, 8'h0F, 8'h00, 8'h10, "R10");
      run_vec(14, 8'h20, 8'h00, 8'h01, "R10");
      check_val("R10", result, 8'h80);
      run_vec(14, 8'h99, 8'h00, 8'h02, "R10");

      for (int k = 0; k < N_RANDOM; k++) begin
         int o;
         o = int'($urandom_range(0, 15));
         run_vec(o, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                 8'($urandom_range(0, 255)), req_of(o));
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule